// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block is the software-visible register file of a per-core local interrupt controller. A single request port carries one access per cycle: a byte offset inside a 4 KB window, an access size of one, two, four or eight bytes, a direction and write data. The block decodes the offset to a register, rejects accesses it cannot serve, and applies each register's own write rules. It returns a registered response on the following cycle.

Priority arbitration and timer counting live in neighbouring blocks. This block hands them the task priority, the software-enable flag, the six vector table entries, the timer load value and the divide setting. It also gives them one-cycle strobes for end-of-interrupt and timer load. It takes back from them the current count, the per-entry status bits and new error bits.

Registers occupy 16-byte slots, and only the first 32-bit word of each slot is populated. The slot decode is ID 0x020, version 0x030, task priority 0x080, EOI 0x0B0, logical destination 0x0D0, destination format 0x0E0, spurious vector 0x0F0, error status 0x280, vector table entries 0x320 through 0x370, timer initial count 0x380, current count 0x390 and divide setting 0x3E0.

Top module: `lic_regs`

## Requirements
- R1: An access to an offset outside the listed slots, or to bytes 4..15 of a listed slot, returns `rsp_err`=1 and read data 0, and changes no register.
- R2: An access whose bytes run past byte 3 of its slot is rejected with `rsp_err`=1 and has no write effect. Such an access has `offset[1:0]` plus size in bytes greater than 4, or uses size code 3 (8 bytes). Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R3: Every accepted request cycle is followed by exactly one cycle of `rsp_valid`. Write responses and responses of write-only locations carry data 0.
- R4: ID and task-priority writes store only bits 7:0, and `task_prio` mirrors the stored task priority. Both reset to 0.
- R5: Logical-destination writes store only bits 31:24. Destination-format writes store bits 31:28 and force bits 27:0 to one. Destination format resets to 0xFFFFFFFF.
- R6: The version register always reads the `VERSION_VAL` parameter, and writes to it are ignored without error.
- R7: A write to the EOI slot stores nothing and raises `eoi_pulse` for exactly the cycle after the write. A read of the EOI slot returns 0.
- R8: In each vector table entry, bit 12 reads `lvt_status[2i]` and bit 14 reads `lvt_status[2i+1]`, and writes cannot change them. All other bits are writable, and each entry resets to 0x00010000.
- R9: The spurious-vector register resets to 0x000000FF. A write to it sets `sw_enable` to bit 8 of the written value, and nothing else changes `sw_enable`, which resets to 0.
- R10: Error status gathers `esr_set` bits. A write while disarmed only arms. A write while armed clears the register and disarms. A read disarms.
- R11: Sub-word accesses address byte lanes by `offset[1:0]`. A write merges only the addressed lanes before the register rule applies, and a read returns the addressed lanes shifted down to bit 0.
- R12: A write to the initial count stores 32 bits and pulses `timer_load` the next cycle. The current count reads `cur_count` and ignores writes. The divide setting keeps only bits 3, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset in the 4 KB window |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 32 | Write data, lane-aligned to bit 0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| esr_set | input | 8 | Error bits to OR into error status |
| lvt_status | input | 12 | Two status bits per vector table entry |
| cur_count | input | 32 | Current timer count from the timer |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| timer_load | output | 1 | Initial-count write strobe |
| timer_init | output | 32 | Stored initial count |
| timer_div | output | 4 | Stored divide setting |
| task_prio | output | 8 | Stored task priority |
| sw_enable | output | 1 | Software-enable flag |
| lvt_cfg | output | 192 | Stored vector table entries, entry i at bits 32i+31:32i |

## Verification
The assertions check several rules on every cycle. Each request is followed by one response, and rejected responses carry zero data. The EOI strobe is only ever preceded by an accepted EOI write. The low destination-format bits stay at one, the ID keeps its upper bits clear, `sw_enable` moves only after a spurious-vector write, and an armed error-status write leaves only the newly arriving bits. The bench scenarios are needed for the rest: exact masked values after writes, lane merging and extraction for sub-word accesses, the arm, read-disarm and clear sequence of the error latch, status bits overriding written data, and proof that rejected writes left the registers untouched.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int unsigned OFS_W   = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_LVT   = 6;
  localparam int unsigned LVT_IW  = 3;
  localparam logic [7:0]  LVT_SLOT = 8'h32;

  typedef enum logic [3:0] {
    RG_NONE, RG_ID, RG_VER, RG_TPR, RG_EOI, RG_LDR, RG_DFR, RG_SVR,
    RG_ESR, RG_LVT, RG_INIT, RG_CUR, RG_DIV
  } lic_reg_e;

  // size code -> bytes touched
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 4'd1;
      2'd1:    size_bytes = 4'd2;
      2'd2:    size_bytes = 4'd4;
      default: size_bytes = 4'd8;
    endcase
  endfunction

  // access fits in the first word of its slot
  function automatic logic fits_word(input logic [3:0] byte_in_slot, input logic [1:0] sz);
    logic [4:0] last;
    last = {3'b000, byte_in_slot[1:0]} + {1'b0, size_bytes(sz)};
    fits_word = (byte_in_slot[3:2] == 2'b00) && (sz != 2'd3) && (last <= 5'd4);
  endfunction

  function automatic lic_reg_e slot_decode(input logic [7:0] slot);
    case (slot)
      8'h02: slot_decode = RG_ID;
      8'h03: slot_decode = RG_VER;
      8'h08: slot_decode = RG_TPR;
      8'h0B: slot_decode = RG_EOI;
      8'h0D: slot_decode = RG_LDR;
      8'h0E: slot_decode = RG_DFR;
      8'h0F: slot_decode = RG_SVR;
      8'h28: slot_decode = RG_ESR;
      8'h38: slot_decode = RG_INIT;
      8'h39: slot_decode = RG_CUR;
      8'h3E: slot_decode = RG_DIV;
      default:
        if (slot >= LVT_SLOT && slot < LVT_SLOT + 8'(N_LVT)) slot_decode = RG_LVT;
        else slot_decode = RG_NONE;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lane, input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 4'b0001 << lane;
      2'd1:    lane_mask = 4'b0011 << lane;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] wd,
                                                   input logic [1:0] lane,
                                                   input logic [1:0] sz);
    logic [3:0] bm;
    logic [DATA_W-1:0] shifted;
    bm = lane_mask(lane, sz);
    shifted = wd << {lane, 3'b000};
    for (int b = 0; b < 4; b++)
      lane_merge[8*b +: 8] = bm[b] ? shifted[8*b +: 8] : old_v[8*b +: 8];
  endfunction

  function automatic logic [DATA_W-1:0] lane_extract(input logic [DATA_W-1:0] v,
                                                     input logic [1:0] lane,
                                                     input logic [1:0] sz);
    logic [DATA_W-1:0] s;
    s = v >> {lane, 3'b000};
    case (sz)
      2'd0:    lane_extract = s & 32'h0000_00FF;
      2'd1:    lane_extract = s & 32'h0000_FFFF;
      default: lane_extract = s;
    endcase
  endfunction

endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  output lic_reg_e         sel,
  output logic [LVT_IW-1:0] lvt_idx,
  output logic             hit,
  output logic             wr_go,
  output logic             rd_go
);

  logic [7:0] slot;
  logic       shape_ok;

  assign slot     = req_offset[OFS_W-1:4];
  assign shape_ok = fits_word(req_offset[3:0], req_size);
  assign sel      = slot_decode(slot);
  assign lvt_idx  = LVT_IW'(slot - LVT_SLOT);
  assign hit      = shape_ok && (sel != RG_NONE);
  assign wr_go    = req_valid && req_write && hit;
  assign rd_go    = req_valid && !req_write && hit;

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0005_0014
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_go,
  input  logic                    rd_go,
  input  lic_reg_e                sel,
  input  logic [LVT_IW-1:0]       lvt_idx,
  input  logic [1:0]              lane,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [7:0]              esr_set,
  input  logic [2*N_LVT-1:0]      lvt_status,
  input  logic [DATA_W-1:0]       cur_count,
  output logic [DATA_W-1:0]       rd_val,
  output logic                    eoi_pulse,
  output logic                    timer_load,
  output logic [DATA_W-1:0]       timer_init,
  output logic [3:0]              timer_div,
  output logic [7:0]              task_prio,
  output logic                    sw_enable,
  output logic [DATA_W*N_LVT-1:0] lvt_cfg
);

  localparam logic [DATA_W-1:0] LVT_RO  = 32'h0000_5000;
  localparam logic [DATA_W-1:0] LVT_RST = 32'h0001_0000;

  logic [DATA_W-1:0] id_q, tpr_q, ldr_q, dfr_q, svr_q, esr_q, init_q;
  logic [3:0]        div_q;
  logic              esr_armed;
  logic [DATA_W-1:0] lvt_q [N_LVT];
  logic [DATA_W-1:0] lvt_view [N_LVT];
  logic [DATA_W-1:0] cur_word, merged;
  logic              lvt_ok;

  assign lvt_ok = (32'(lvt_idx) < N_LVT);

  // status bits come from the neighbour, never from stored data
  for (genvar i = 0; i < N_LVT; i++) begin : g_lvt
    assign lvt_view[i] = (lvt_q[i] & ~LVT_RO)
                       | {17'd0, lvt_status[2*i+1], 1'b0, lvt_status[2*i], 12'd0};
    assign lvt_cfg[DATA_W*i +: DATA_W] = lvt_q[i];
  end

  always_comb begin
    case (sel)
      RG_ID:   cur_word = id_q;
      RG_VER:  cur_word = VERSION_VAL;
      RG_TPR:  cur_word = tpr_q;
      RG_LDR:  cur_word = ldr_q;
      RG_DFR:  cur_word = dfr_q;
      RG_SVR:  cur_word = svr_q;
      RG_ESR:  cur_word = esr_q;
      RG_LVT:  cur_word = lvt_ok ? lvt_view[lvt_idx] : '0;
      RG_INIT: cur_word = init_q;
      RG_CUR:  cur_word = cur_count;
      RG_DIV:  cur_word = {28'd0, div_q};
      default: cur_word = '0;
    endcase
  end

  assign merged = lane_merge(cur_word, wdata, lane, req_size);
  assign rd_val = lane_extract(cur_word, lane, req_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q       <= '0;
      tpr_q      <= '0;
      ldr_q      <= '0;
      dfr_q      <= '1;
      svr_q      <= 32'h0000_00FF;
      esr_q      <= '0;
      esr_armed  <= 1'b0;
      init_q     <= '0;
      div_q      <= '0;
      sw_enable  <= 1'b0;
      eoi_pulse  <= 1'b0;
      timer_load <= 1'b0;
      for (int i = 0; i < N_LVT; i++) lvt_q[i] <= LVT_RST;
    end else begin
      eoi_pulse  <= wr_go && (sel == RG_EOI);
      timer_load <= wr_go && (sel == RG_INIT);
      if (rd_go && sel == RG_ESR) esr_armed <= 1'b0;
      if (wr_go && sel == RG_ESR) begin
        if (esr_armed) begin
          esr_q     <= {24'd0, esr_set};
          esr_armed <= 1'b0;
        end else begin
          esr_q     <= esr_q | {24'd0, esr_set};
          esr_armed <= 1'b1;
        end
      end else begin
        esr_q <= esr_q | {24'd0, esr_set};
      end
      if (wr_go) begin
        case (sel)
          RG_ID:   id_q  <= merged & 32'h0000_00FF;
          RG_TPR:  tpr_q <= merged & 32'h0000_00FF;
          RG_LDR:  ldr_q <= merged & 32'hFF00_0000;
          RG_DFR:  dfr_q <= merged | 32'h0FFF_FFFF;
          RG_SVR: begin
            svr_q     <= merged;
            sw_enable <= merged[8];
          end
          RG_LVT:  if (lvt_ok) lvt_q[lvt_idx] <= (merged & ~LVT_RO) | (lvt_q[lvt_idx] & LVT_RO);
          RG_INIT: init_q <= merged;
          RG_DIV:  div_q  <= merged[3:0] & 4'b1011;
          default: ;
        endcase
      end
    end
  end

  assign timer_init = init_q;
  assign timer_div  = div_q;
  assign task_prio  = tpr_q[7:0];

  a_r5_dfr_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    dfr_q[27:0] == 28'hFFF_FFFF);
  a_r4_id_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[31:8] == 24'd0);
  a_r9_swen_only_by_svr: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_enable) |-> $past(wr_go && sel == RG_SVR));
  a_r10_esr_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel == RG_ESR && esr_armed) |=> (esr_q == {24'd0, $past(esr_set)} && !esr_armed));

endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [11:0]  req_offset,
  input  logic [1:0]   req_size,
  input  logic [31:0]  req_wdata,
  output logic         rsp_valid,
  output logic         rsp_err,
  output logic [31:0]  rsp_rdata,
  input  logic [7:0]   esr_set,
  input  logic [11:0]  lvt_status,
  input  logic [31:0]  cur_count,
  output logic         eoi_pulse,
  output logic         timer_load,
  output logic [31:0]  timer_init,
  output logic [3:0]   timer_div,
  output logic [7:0]   task_prio,
  output logic         sw_enable,
  output logic [191:0] lvt_cfg
);

  lic_reg_e          dec_sel;
  logic [LVT_IW-1:0] dec_lvt;
  logic              dec_hit, dec_wr, dec_rd;
  logic [DATA_W-1:0] rf_rd;

  lic_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_offset(req_offset),
    .req_size  (req_size),
    .sel       (dec_sel),
    .lvt_idx   (dec_lvt),
    .hit       (dec_hit),
    .wr_go     (dec_wr),
    .rd_go     (dec_rd)
  );

  lic_regfile #(.VERSION_VAL(VERSION_VAL)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (dec_wr),
    .rd_go     (dec_rd),
    .sel       (dec_sel),
    .lvt_idx   (dec_lvt),
    .lane      (req_offset[1:0]),
    .req_size  (req_size),
    .wdata     (req_wdata),
    .esr_set   (esr_set),
    .lvt_status(lvt_status),
    .cur_count (cur_count),
    .rd_val    (rf_rd),
    .eoi_pulse (eoi_pulse),
    .timer_load(timer_load),
    .timer_init(timer_init),
    .timer_div (timer_div),
    .task_prio (task_prio),
    .sw_enable (sw_enable),
    .lvt_cfg   (lvt_cfg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !dec_hit;
      rsp_rdata <= dec_rd ? rf_rd : '0;
    end
  end

  a_r3_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == 32'd0);
  a_r7_eoi_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(req_valid && req_write && dec_hit && dec_sel == RG_EOI));

endmodule

// File: tb/lic_regs_tb.sv
`timescale 1ns/1ps
module lic_regs_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]  req_offset = '0;
  logic [1:0]   req_size = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [7:0]   esr_set = '0;
  logic [11:0]  lvt_status = '0;
  logic [31:0]  cur_count = '0;
  logic         eoi_pulse, timer_load, sw_enable;
  logic [31:0]  timer_init;
  logic [3:0]   timer_div;
  logic [7:0]   task_prio;
  logic [191:0] lvt_cfg;

  int checks = 0;
  int errors = 0;
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  lic_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .esr_set(esr_set), .lvt_status(lvt_status), .cur_count(cur_count),
    .eoi_pulse(eoi_pulse), .timer_load(timer_load), .timer_init(timer_init),
    .timer_div(timer_div), .task_prio(task_prio), .sw_enable(sw_enable),
    .lvt_cfg(lvt_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // driver: one access, expectation queued for the monitor
  task automatic acc(input bit w, input logic [11:0] off, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] exp_d,
                     input bit exp_e, input string tag);
    req_valid  = 1'b1;
    req_write  = w;
    req_offset = off;
    req_size   = sz;
    req_wdata  = d;
    q_data.push_back(w ? 32'd0 : exp_d);
    q_err.push_back(exp_e);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected response actual=0x%08h expected=none", rsp_rdata);
      end else begin
        logic [31:0] ed;
        logic        ee;
        string       et;
        ed = q_data.pop_front();
        ee = q_err.pop_front();
        et = q_tag.pop_front();
        chk({et, " data"}, rsp_rdata, ed);
        chk({et, " err"}, {31'd0, rsp_err}, {31'd0, ee});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 reset sw_enable", {31'd0, sw_enable}, 32'd0);
    chk("R4 reset task_prio", {24'd0, task_prio}, 32'd0);
    chk("R3 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    acc(0, 12'h020, 2, 0, 32'h0, 0, "R4 reset id");
    acc(0, 12'h0E0, 2, 0, 32'hFFFF_FFFF, 0, "R5 reset dfr");
    acc(0, 12'h0F0, 2, 0, 32'h0000_00FF, 0, "R9 reset svr");
    acc(0, 12'h320, 2, 0, 32'h0001_0000, 0, "R8 reset lvt0");

    // R4 masking
    acc(1, 12'h020, 2, 32'hAABB_CCDD, 0, 0, "R4 wr id");
    acc(0, 12'h020, 2, 0, 32'h0000_00DD, 0, "R4 rd id");
    acc(1, 12'h080, 2, 32'h0000_1234, 0, 0, "R4 wr tpr");
    chk("R4 task_prio", {24'd0, task_prio}, 32'h34);
    acc(0, 12'h080, 2, 0, 32'h0000_0034, 0, "R4 rd tpr");

    // R5 destination registers
    acc(1, 12'h0D0, 2, 32'h1234_5678, 0, 0, "R5 wr ldr");
    acc(0, 12'h0D0, 2, 0, 32'h1200_0000, 0, "R5 rd ldr");
    acc(1, 12'h0E0, 2, 32'h0000_0000, 0, 0, "R5 wr dfr0");
    acc(0, 12'h0E0, 2, 0, 32'h0FFF_FFFF, 0, "R5 rd dfr0");
    acc(1, 12'h0E0, 2, 32'hA000_0000, 0, 0, "R5 wr dfrA");
    acc(0, 12'h0E0, 2, 0, 32'hAFFF_FFFF, 0, "R5 rd dfrA");

    // R6 version
    acc(1, 12'h030, 2, 32'h0, 0, 0, "R6 wr ver");
    acc(0, 12'h030, 2, 0, 32'h0005_0014, 0, "R6 rd ver");

    // R7 EOI
    acc(1, 12'h0B0, 2, 32'hFFFF_FFFF, 0, 0, "R7 wr eoi");
    chk("R7 eoi high", {31'd0, eoi_pulse}, 32'd1);
    @(negedge clk);
    chk("R7 eoi low", {31'd0, eoi_pulse}, 32'd0);
    acc(0, 12'h0B0, 2, 0, 32'h0, 0, "R7 rd eoi");

    // R8 vector table status bits
    acc(1, 12'h340, 2, 32'hFFFF_FFFF, 0, 0, "R8 wr lvt2");
    acc(0, 12'h340, 2, 0, 32'hFFFF_AFFF, 0, "R8 rd lvt2 st0");
    lvt_status = 12'b0000_0011_0000;
    acc(0, 12'h340, 2, 0, 32'hFFFF_FFFF, 0, "R8 rd lvt2 st1");
    acc(1, 12'h340, 2, 32'h0000_0000, 0, 0, "R8 wr lvt2 zero");
    acc(0, 12'h340, 2, 0, 32'h0000_5000, 0, "R8 rd lvt2 st kept");
    lvt_status = '0;
    chk("R8 lvt_cfg2", lvt_cfg[64 +: 32], 32'h0);

    // R9 spurious vector
    acc(1, 12'h0F0, 2, 32'h0000_01FF, 0, 0, "R9 wr svr on");
    chk("R9 sw_enable on", {31'd0, sw_enable}, 32'd1);
    acc(0, 12'h0F0, 2, 0, 32'h0000_01FF, 0, "R9 rd svr");
    acc(1, 12'h0F0, 2, 32'h0000_00FF, 0, 0, "R9 wr svr off");
    chk("R9 sw_enable off", {31'd0, sw_enable}, 32'd0);

    // R10 error status latch
    esr_set = 8'h04;
    @(negedge clk);
    esr_set = 8'h00;
    acc(1, 12'h280, 2, 0, 0, 0, "R10 arm");
    acc(0, 12'h280, 2, 0, 32'h0000_0004, 0, "R10 armed keeps");
    acc(1, 12'h280, 2, 0, 0, 0, "R10 rearm");
    acc(1, 12'h280, 2, 0, 0, 0, "R10 clear");
    acc(0, 12'h280, 2, 0, 32'h0, 0, "R10 cleared");

    // R1 decode errors, no state change
    acc(0, 12'h040, 2, 0, 32'h0, 1, "R1 unlisted rd");
    acc(1, 12'h024, 2, 32'h11, 0, 1, "R1 upper word wr");
    acc(1, 12'h028, 2, 32'h77, 0, 1, "R1 upper word wr2");
    acc(0, 12'h020, 2, 0, 32'h0000_00DD, 0, "R1 id untouched");

    // R2 spanning
    acc(1, 12'h083, 1, 32'h0000_FFFF, 0, 1, "R2 span half");
    acc(1, 12'h080, 3, 32'h0000_0099, 0, 1, "R2 size8");
    acc(0, 12'h080, 2, 0, 32'h0000_0034, 0, "R2 tpr untouched");
    chk("R2 task_prio", {24'd0, task_prio}, 32'h34);

    // R11 byte lanes
    acc(1, 12'h0D3, 0, 32'h0000_005A, 0, 0, "R11 byte wr lane3");
    acc(0, 12'h0D0, 2, 0, 32'h5A00_0000, 0, "R11 full rd");
    acc(0, 12'h0D3, 0, 0, 32'h0000_005A, 0, "R11 byte rd");
    acc(0, 12'h0D2, 1, 0, 32'h0000_5A00, 0, "R11 half rd");

    // R12 timer interface
    acc(1, 12'h380, 2, 32'h0000_1000, 0, 0, "R12 wr init");
    chk("R12 timer_load", {31'd0, timer_load}, 32'd1);
    chk("R12 timer_init", timer_init, 32'h1000);
    @(negedge clk);
    chk("R12 timer_load low", {31'd0, timer_load}, 32'd0);
    cur_count = 32'h0000_0777;
    acc(1, 12'h390, 2, 32'h0, 0, 0, "R12 wr cur");
    acc(0, 12'h390, 2, 0, 32'h0000_0777, 0, "R12 rd cur");
    acc(1, 12'h3E0, 2, 32'hFF, 0, 0, "R12 wr div");
    chk("R12 timer_div", {28'd0, timer_div}, 32'hB);
    acc(0, 12'h3E0, 2, 0, 32'h0000_000B, 0, "R12 rd div");

    repeat (2) @(negedge clk);
    chk("R3 all responses seen", q_data.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule